// File: doc/BRIEF.md
# Serial Receive Buffer

This block recovers bytes from an asynchronous serial line and keeps them in a 32-entry on-chip queue until the host collects them. A 16-bit rate value, supplied as separate low and high bytes, divides the system clock into a sampling tick at sixteen times the bit rate. A falling edge on the line, after a two-stage synchronizer, starts a frame. The line is checked again half a bit later, and each following bit is sampled near its centre.

A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. The start, parity and stop bits are removed. Only a byte whose frame is free of errors is written into the queue. The host sees the oldest byte and a ready flag on the output. A one-cycle read strobe removes that byte. Parity, framing and overrun problems each set a sticky flag. The flags stay set until a clear strobe.

Top module: `serial_rx_buffer`

## Requirements
- R1: The sampling tick period is max(D,1) clock cycles, where D = {rate_hi_i, rate_lo_i} (rate_hi_i is the upper byte). One bit lasts 16 ticks. Both rate bytes take part in setting D.
- R2: A frame is a low start bit, then 8 data bits least significant bit first, then a parity bit when parity_en_i is 1, then a stop bit. Only the data byte is stored.
- R3: With parity_en_i = 1, parity_odd_i = 0 selects even parity (data plus parity bit hold an even number of ones). parity_odd_i = 1 selects odd parity. A frame that matches the selected parity is stored and leaves par_err_o low.
- R4: When the stop bit is low at its sample point, frm_err_o goes high and stays high, and the byte is not stored.
- R5: When parity is enabled and the received parity bit does not match, par_err_o goes high and stays high, and the byte is not stored.
- R6: A good byte that completes while the queue holds 32 bytes, with no read in that cycle, sets ovr_err_o (sticky). That byte is dropped and the stored bytes are unchanged.
- R7: The queue holds 32 bytes and returns them in arrival order, across pointer wrap-around.
- R8: byte_ready_o is low exactly when the queue is empty. When it is high, rx_byte_o shows the oldest byte, and a read strobe removes that byte.
- R9: A one-cycle err_clr_i pulse clears all three error flags. An error that is detected in the same cycle as the clear still sets its flag.
- R10: A low pulse on rx_i that is high again at the half-bit check is ignored: nothing is stored and no flag is set.
- R11: When a good byte completes in the same cycle as a read strobe on a full queue, the byte is stored and ovr_err_o stays low.
- R12: After reset, byte_ready_o and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_lo_i | input | 8 | Low byte of the tick divisor |
| rate_hi_i | input | 8 | High byte of the tick divisor |
| parity_en_i | input | 1 | Frame carries a parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| rd_i | input | 1 | Read strobe; removes the oldest byte |
| err_clr_i | input | 1 | Clears the sticky error flags |
| rx_byte_o | output | 8 | Oldest stored byte |
| byte_ready_o | output | 1 | Queue is not empty |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |

## Verification
Two events can land on the same clock edge: the write of a newly completed byte and a host read, both on a full queue. The bench fills the queue to 32 entries. It then counts clock edges from the falling start edge it drives and raises rd_i only for the cycle in which the stop-bit result is written. The design must store the new byte, keep ovr_err_o low, and later return all 32 bytes in order, ending with the new one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a zero divisor behaves like one
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = !restart_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q >= lim)    cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              restart_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              frm_bad_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] PH_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] PH_END  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              rx_q;
  logic              par_bad_q;

  // start only on a true high-to-low transition
  assign restart_o = (state_q == ST_IDLE) && rx_q && !rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ph_q      <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      rx_q      <= 1'b1;
      par_bad_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      par_bad_o <= 1'b0;
      frm_bad_o <= 1'b0;
    end else begin
      rx_q   <= rx_i;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (restart_o) begin
            state_q   <= ST_START;
            ph_q      <= '0;
            idx_q     <= '0;
            par_bad_q <= 1'b0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (ph_q == PH_MID) begin
              ph_q    <= '0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (ph_q == PH_END) begin
              ph_q <= '0;
              sh_q <= {rx_i, sh_q[DATA_W-1:1]};
              if (idx_q == IDX_END) begin
                idx_q   <= '0;
                state_q <= par_en_i ? ST_PAR : ST_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            if (ph_q == PH_END) begin
              ph_q      <= '0;
              par_bad_q <= ((^sh_q) ^ rx_i) != par_odd_i;
              state_q   <= ST_STOP;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (ph_q == PH_END) begin
              ph_q      <= '0;
              done_o    <= 1'b1;
              data_o    <= sh_q;
              par_bad_o <= par_bad_q;
              frm_bad_o <= !rx_i;
              state_q   <= ST_IDLE;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       rd_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       drop_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             empty, full, pop, push;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_MAX);
  assign pop     = rd_i && !empty;
  assign push    = wr_i && (!full || pop);  // a same-cycle read frees a slot
  assign drop_o  = wr_i && !push;
  assign rdata_o = mem[rp_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) begin
    if (push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PTR_END) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PTR_END) ? '0 : rp_q + 1'b1;
      unique case ({push, pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 32,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rate_lo_i,
  input  logic [7:0]        rate_hi_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              rx_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              byte_ready_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  localparam int DIV_W = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic              rx_s, tick, restart;
  logic              frame_done, par_bad, frm_bad, good, drop;
  logic [DATA_W-1:0] frame_data;
  logic [LVL_W-1:0]  fill;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .div_i     ({rate_hi_i, rate_lo_i}),
    .restart_i (restart),
    .tick_o    (tick)
  );

  rx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_eng (
    .clk_i, .rst_ni,
    .rx_i      (rx_s),
    .tick_i    (tick),
    .par_en_i  (parity_en_i),
    .par_odd_i (parity_odd_i),
    .restart_o (restart),
    .done_o    (frame_done),
    .data_o    (frame_data),
    .par_bad_o (par_bad),
    .frm_bad_o (frm_bad)
  );

  assign good = frame_done && !par_bad && !frm_bad;

  rx_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i    (good),
    .wdata_i (frame_data),
    .rd_i    (rd_i),
    .rdata_o (rx_byte_o),
    .level_o (fill),
    .drop_o  (drop)
  );

  assign byte_ready_o = (fill != '0);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
    end else begin
      par_err_o <= (frame_done && par_bad) || (par_err_o && !err_clr_i);
      frm_err_o <= (frame_done && frm_bad) || (frm_err_o && !err_clr_i);
      ovr_err_o <= drop || (ovr_err_o && !err_clr_i);
    end
  end
endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             err_clr_i,
  input logic             byte_ready_o,
  input logic             par_err_o,
  input logic             frm_err_o,
  input logic             ovr_err_o,
  input logic             frame_done,
  input logic [LVL_W-1:0] fill
);
  p_level_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= LVL_W'(DEPTH));

  p_level_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill == $past(fill) - 1'b1));

  p_ready_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_ready_o) |-> $past(frame_done));

  p_ready_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byte_ready_o) |-> $past(rd_i));

  p_sticky_frm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o && !err_clr_i |=> frm_err_o);

  p_sticky_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !err_clr_i |=> par_err_o);

  p_sticky_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o && !err_clr_i |=> ovr_err_o);

  p_ovr_when_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> ($past(fill) == LVL_W'(DEPTH)));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !frame_done |=> !par_err_o && !frm_err_o && !ovr_err_o);
endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .err_clr_i    (err_clr_i),
  .byte_ready_o (byte_ready_o),
  .par_err_o    (par_err_o),
  .frm_err_o    (frm_err_o),
  .ovr_err_o    (ovr_err_o),
  .frame_done   (frame_done),
  .fill         (fill)
);

// File: tb/serial_rx_buffer_bench.sv
module serial_rx_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_lo = 8'd2, rate_hi = 8'd0;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       rx = 1'b1;
  logic       rd_mon = 1'b0, rd_co = 1'b0, rd;
  logic       err_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       byte_ready, par_err, frm_err, ovr_err;

  int    n_chk = 0, n_bad = 0;
  int    bitc = 32;
  bit    drain_en = 1'b0;
  string cur_req = "R2";
  byte unsigned q[$];

  assign rd = rd_mon | rd_co;
  always #2.5 clk = ~clk;

  serial_rx_buffer u_serial_rx_buffer (
    .clk_i(clk), .rst_ni(rst_n), .rate_lo_i(rate_lo), .rate_hi_i(rate_hi),
    .parity_en_i(par_en), .parity_odd_i(par_odd), .rx_i(rx), .rd_i(rd),
    .err_clr_i(err_clr), .rx_byte_o(rx_byte), .byte_ready_o(byte_ready),
    .par_err_o(par_err), .frm_err_o(frm_err), .ovr_err_o(ovr_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit par_of(input byte unsigned d, input bit odd);
    return odd ? ~^d : ^d;
  endfunction

  // driver: one frame, bits change on falling clock edges
  task automatic send(input byte unsigned d, input bit pon, input bit pbit, input bit stopb);
    @(negedge clk); rx = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (bitc) @(negedge clk);
    end
    if (pon) begin
      rx = pbit;
      repeat (bitc) @(negedge clk);
    end
    rx = stopb;
    repeat (bitc) @(negedge clk);
    rx = 1'b1;
    repeat (bitc) @(negedge clk);
  endtask

  task automatic send_good(input byte unsigned d);
    q.push_back(d);
    send(d, par_en, par_of(d, par_odd), 1'b1);
  endtask

  task automatic drain_all();
    drain_en = 1'b1;
    for (int i = 0; i < 2000 && (q.size() != 0 || byte_ready); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    drain_en = 1'b0;
    chk(q.size() == 0, {cur_req, " queue drained"}, q.size(), 0);
    chk(!byte_ready, "R8 ready low when empty", byte_ready, 0);
  endtask

  task automatic clear_errs();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rd_mon) rd_mon = 1'b0;
      else if (drain_en && byte_ready) begin
        if (q.size() == 0) chk(1'b0, {cur_req, " unexpected byte"}, rx_byte, -1);
        else begin
          automatic byte unsigned e = q.pop_front();
          chk(rx_byte == e, {cur_req, " data"}, rx_byte, e);
        end
        rd_mon = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!byte_ready, "R12 ready after reset", byte_ready, 0);
    chk({par_err, frm_err, ovr_err} == 3'b000, "R12 flags after reset", {par_err, frm_err, ovr_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 plain frames
    cur_req = "R2";
    send_good(8'h55); send_good(8'hA3); send_good(8'h00); send_good(8'hFF);
    drain_all();

    // R3 parity modes
    cur_req = "R3";
    par_en = 1'b1; par_odd = 1'b0;
    send_good(8'h3C); send_good(8'h07);
    par_odd = 1'b1;
    send_good(8'h07); send_good(8'hE1);
    drain_all();
    chk(!par_err, "R3 no parity error on matching frames", par_err, 0);

    // R5 parity error: even mode, 0x01 with parity bit 0
    cur_req = "R5";
    par_odd = 1'b0;
    send(8'h01, 1'b1, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    chk(par_err, "R5 parity flag", par_err, 1);
    chk(!byte_ready, "R5 bad byte not stored", byte_ready, 0);
    send_good(8'h42);
    drain_all();
    chk(par_err, "R5 parity flag sticky", par_err, 1);
    // R9 clear
    clear_errs();
    @(negedge clk);
    chk(!par_err, "R9 clear parity flag", par_err, 0);

    // R4 framing error
    cur_req = "R4";
    par_en = 1'b0;
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk(frm_err, "R4 framing flag", frm_err, 1);
    chk(!byte_ready, "R4 bad byte not stored", byte_ready, 0);
    repeat (50) @(negedge clk);
    chk(frm_err, "R4 framing flag sticky", frm_err, 1);
    clear_errs();
    @(negedge clk);
    chk(!frm_err, "R9 clear framing flag", frm_err, 0);

    // R10 glitch
    cur_req = "R10";
    @(negedge clk); rx = 1'b0;
    repeat (5) @(negedge clk); rx = 1'b1;
    repeat (400) @(negedge clk);
    chk(!byte_ready, "R10 glitch stores nothing", byte_ready, 0);
    chk({par_err, frm_err, ovr_err} == 3'b000, "R10 glitch sets no flag", {par_err, frm_err, ovr_err}, 0);
    send_good(8'h96);
    drain_all();

    // R6 / R7 fill then overrun
    cur_req = "R7";
    for (int i = 0; i < 32; i++) send_good(byte'(i * 7 + 1));
    chk(byte_ready, "R7 ready with full queue", byte_ready, 1);
    chk(!ovr_err, "R7 no overrun at 32 entries", ovr_err, 0);
    send(8'hEE, 1'b0, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    chk(ovr_err, "R6 overrun flag", ovr_err, 1);
    cur_req = "R6";
    drain_all();
    chk(ovr_err, "R6 overrun flag sticky", ovr_err, 1);
    clear_errs();
    @(negedge clk);
    chk(!ovr_err, "R9 clear overrun flag", ovr_err, 0);

    // R11 write and read in the same cycle on a full queue
    cur_req = "R11";
    for (int i = 0; i < 32; i++) send_good(byte'(8'hC0 ^ i));
    q.push_back(8'h99);
    fork
      send(8'h99, 1'b0, 1'b0, 1'b1);
      begin
        // write edge is the (152*D + 4)th rising edge after the start falling edge
        @(negedge clk);
        repeat (152 * 2 + 3) @(negedge clk);
        begin
          automatic byte unsigned e = q.pop_front();
          chk(rx_byte == e, "R11 head before coincident read", rx_byte, e);
        end
        rd_co = 1'b1;
        @(negedge clk);
        rd_co = 1'b0;
      end
    join
    chk(!ovr_err, "R11 no overrun on coincident read", ovr_err, 0);
    drain_all();

    // R1 divisor uses the high byte: D = 256
    cur_req = "R1";
    rate_hi = 8'd1; rate_lo = 8'd0; bitc = 16 * 256;
    send_good(8'hC6);
    drain_all();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule